// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Byte-Lane Read Steering

This block receives asynchronous serial words on a single input line and hands the data byte to a processor with a 24-bit data bus. Incoming bits are collected in a shift register that the processor cannot see. A completed word's data byte is then copied into a byte-wide holding register. Because the two registers are separate, software can read one byte while the next word is still arriving.

The holding register answers at three read addresses. Each address places the byte in a different 8-bit lane of the 24-bit bus and drives zero on the other two lanes. Software can therefore pack three received bytes into one word by ORing the results of a low-lane read, a middle-lane read and a high-lane read.

A 3-bit format code selects the serial word layout. One control bit chooses the bit-timing source: an internal divider of the system clock, or an external clock pin that runs at 16 times the bit rate. A receive-full flag, an overrun flag and a framing-error flag report the state of the holding register.

Top module: `serial_rx_lanes`

## Requirements
- R1: After reset, `rx_full_o`, `overrun_o` and `frame_err_o` are 0, and a read at any address returns 0.
- R2: With format code 000, a frame is received with the least significant bit first. A frame is a low start bit, 8 data bits and a high stop bit, each 16 oversample ticks long. The 8 data bits become the held byte.
- R3: Lane steering works as follows:
  - While `rd_i` is high, address 0 puts the held byte on bits 7:0, address 1 on bits 15:8 and address 2 on bits 23:16. All other bits are 0.
  - Address 3 returns all zeros and changes no flag.
  - While `rd_i` is low, `rd_data_o` is 0.
- R4: `rx_full_o` sets when a byte enters the holding register. It clears after one read at address 0, 1 or 2.
- R5: Format codes 001 and 010 receive 7 data bits followed by a parity bit. The held byte is the 7 data bits with bit 7 equal to 0. The parity bit is not checked.
- R6: Format code 011 receives 8 data bits followed by a ninth bit. The held byte is the first 8 bits. Codes 100 to 111 behave exactly as code 000.
- R7: If a word completes while `rx_full_o` is 1:
  - The held byte is kept and the new byte is discarded.
  - `overrun_o` sets.
  - The next read at address 0, 1 or 2 clears `overrun_o` and `rx_full_o`.
- R8: If the stop bit is sampled low, `frame_err_o` sets and the byte is still transferred. The next transfer with a high stop bit clears `frame_err_o`.
- R9: The start bit is confirmed 8 ticks after the falling edge. A low pulse shorter than 8 ticks starts no word.
- R10: With `clk_src_i` = 0, one tick occurs every DIV system clocks. With `clk_src_i` = 1, one tick occurs on each rising edge of `ext_clk_i`.
- R11: The held byte stays readable and unchanged while the next word shifts in. It changes only when a transfer occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial receive line, idle high |
| fmt_sel_i | input | 3 | Serial word format code |
| clk_src_i | input | 1 | Tick source: 0 internal divider, 1 external clock |
| ext_clk_i | input | 1 | External clock at 16x the bit rate |
| rd_i | input | 1 | Read strobe |
| rd_addr_i | input | 2 | Read address: 0 low lane, 1 middle lane, 2 high lane |
| rd_data_o | output | 24 | Read data with the byte steered into its lane |
| rx_full_o | output | 1 | Holding register holds an unread byte |
| overrun_o | output | 1 | A word was lost while the byte was unread |
| frame_err_o | output | 1 | The last transferred word had a low stop bit |

## Verification
An oversample counter that is off by one shifts every sample away from the bit centre. A byte sweep then shows a corrupted value on `rd_data_o` at the first read after the frame. A wrong lane decode shows up at once as a nonzero byte outside the addressed lane, in the same cycle as the read strobe. A flag that is not cleared or not set shows at the next read or the next word: `rx_full_o` stays high one cycle after a read, or `overrun_o` fails to rise when a second word lands on an unread byte.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  typedef enum logic [1:0] {
    FMT_D8,
    FMT_D7P,
    FMT_D9
  } rx_fmt_e;

  function automatic rx_fmt_e decode_fmt(input logic [2:0] code);
    case (code)
      3'b001, 3'b010: decode_fmt = FMT_D7P;
      3'b011:         decode_fmt = FMT_D9;
      default:        decode_fmt = FMT_D8;
    endcase
  endfunction

  function automatic logic [3:0] frame_bits(input rx_fmt_e f);
    frame_bits = (f == FMT_D9) ? 4'd9 : 4'd8;
  endfunction

endpackage

// File: rtl/srx_tick_gen.sv
module srx_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_src_i,
  input  logic ext_clk_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] div_q, div_d;
  logic [2:0]    ext_q;
  logic          int_tick, ext_tick;

  assign int_tick = (div_q == CW'(DIV - 1));
  assign ext_tick = ext_q[1] & ~ext_q[2];
  assign tick_o   = clk_src_i ? ext_tick : int_tick;

  always_comb begin
    div_d = int_tick ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ext_q <= '0;
    end else begin
      div_q <= div_d;
      ext_q <= {ext_q[1:0], ext_clk_i};
    end
  end
endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
  import srx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic [2:0] fmt_i,
  output logic       done_o,
  output logic [7:0] byte_o,
  output logic       ferr_o
);
  localparam int OW = $clog2(OSR);
  localparam logic [OW-1:0] MID  = OW'(OSR / 2 - 1);
  localparam logic [OW-1:0] LAST = OW'(OSR - 1);

  rx_state_e     st_q, st_d;
  rx_fmt_e       fmt_q, fmt_d;
  logic [OW-1:0] os_q, os_d;
  logic [3:0]    bit_q, bit_d;
  logic [8:0]    sr_q, sr_d;
  logic [2:0]    sync_q;
  logic          rx_s, fall;

  assign rx_s = sync_q[1];
  assign fall = sync_q[2] & ~sync_q[1];

  always_comb begin
    st_d   = st_q;
    fmt_d  = fmt_q;
    os_d   = os_q;
    bit_d  = bit_q;
    sr_d   = sr_q;
    done_o = 1'b0;
    ferr_o = 1'b0;
    case (st_q)
      ST_IDLE: if (fall) begin
        st_d  = ST_START;
        os_d  = '0;
        fmt_d = decode_fmt(fmt_i);
      end
      ST_START: if (tick_i) begin
        if (os_q == MID) begin
          os_d  = '0;
          bit_d = '0;
          st_d  = rx_s ? ST_IDLE : ST_DATA;
        end else begin
          os_d = os_q + 1'b1;
        end
      end
      ST_DATA: if (tick_i) begin
        if (os_q == LAST) begin
          os_d = '0;
          sr_d = {rx_s, sr_q[8:1]};
          if (bit_q == frame_bits(fmt_q) - 4'd1) st_d = ST_STOP;
          else bit_d = bit_q + 4'd1;
        end else begin
          os_d = os_q + 1'b1;
        end
      end
      default: if (tick_i) begin
        if (os_q == LAST) begin
          done_o = 1'b1;
          ferr_o = ~rx_s;
          st_d   = ST_IDLE;
        end else begin
          os_d = os_q + 1'b1;
        end
      end
    endcase
  end

  always_comb begin
    case (fmt_q)
      FMT_D9:  byte_o = sr_q[7:0];
      FMT_D7P: byte_o = {1'b0, sr_q[7:1]};
      default: byte_o = sr_q[8:1];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      fmt_q  <= FMT_D8;
      os_q   <= '0;
      bit_q  <= '0;
      sr_q   <= '0;
      sync_q <= 3'b111;
    end else begin
      st_q   <= st_d;
      fmt_q  <= fmt_d;
      os_q   <= os_d;
      bit_q  <= bit_d;
      sr_q   <= sr_d;
      sync_q <= {sync_q[1:0], rxd_i};
    end
  end
endmodule

// File: rtl/srx_hold_lanes.sv
module srx_hold_lanes #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 3,
  parameter int AW     = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    done_i,
  input  logic [BYTE_W-1:0]       byte_i,
  input  logic                    ferr_i,
  input  logic                    rd_i,
  input  logic [AW-1:0]           rd_addr_i,
  output logic [BYTE_W*LANES-1:0] rd_data_o,
  output logic                    full_o,
  output logic                    ovr_o,
  output logic                    ferr_o
);
  logic [BYTE_W-1:0] hold_q, hold_d;
  logic              full_q, full_d, ovr_q, ovr_d, ferr_q, ferr_d;
  logic              rd_hit, busy;

  assign rd_hit = rd_i && (rd_addr_i < AW'(LANES));
  assign busy   = full_q & ~rd_hit;

  always_comb begin
    hold_d = hold_q;
    full_d = full_q;
    ovr_d  = ovr_q;
    ferr_d = ferr_q;
    if (done_i) begin
      if (!busy) begin
        hold_d = byte_i;
        full_d = 1'b1;
        ferr_d = ferr_i;
        if (rd_hit) ovr_d = 1'b0;
      end else begin
        ovr_d = 1'b1;
      end
    end else if (rd_hit) begin
      full_d = 1'b0;
      ovr_d  = 1'b0;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_data_o[g*BYTE_W +: BYTE_W] =
      (rd_i && rd_addr_i == AW'(g)) ? hold_q : '0;
  end

  assign full_o = full_q;
  assign ovr_o  = ovr_q;
  assign ferr_o = ferr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      full_q <= full_d;
      ovr_q  <= ovr_d;
      ferr_q <= ferr_d;
    end
  end
endmodule

// File: rtl/serial_rx_lanes.sv
module serial_rx_lanes #(
  parameter int DIV = 4,
  parameter int OSR = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rxd_i,
  input  logic [2:0]  fmt_sel_i,
  input  logic        clk_src_i,
  input  logic        ext_clk_i,
  input  logic        rd_i,
  input  logic [1:0]  rd_addr_i,
  output logic [23:0] rd_data_o,
  output logic        rx_full_o,
  output logic        overrun_o,
  output logic        frame_err_o
);
  logic       tick;
  logic       word_done;
  logic [7:0] word_byte;
  logic       word_ferr;

  srx_tick_gen #(.DIV(DIV)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_src_i (clk_src_i),
    .ext_clk_i (ext_clk_i),
    .tick_o    (tick)
  );

  srx_frame_fsm #(.OSR(OSR)) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick),
    .rxd_i  (rxd_i),
    .fmt_i  (fmt_sel_i),
    .done_o (word_done),
    .byte_o (word_byte),
    .ferr_o (word_ferr)
  );

  srx_hold_lanes #(.BYTE_W(8), .LANES(3), .AW(2)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_i    (word_done),
    .byte_i    (word_byte),
    .ferr_i    (word_ferr),
    .rd_i      (rd_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .full_o    (rx_full_o),
    .ovr_o     (overrun_o),
    .ferr_o    (frame_err_o)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_i,
  input logic [1:0]  rd_addr_i,
  input logic [23:0] rd_data_o,
  input logic        rx_full_o,
  input logic        overrun_o,
  input logic        word_done
);
  // R3
  lane_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_i || rd_addr_i == 2'd3) |-> (rd_data_o == 24'd0));

  // R3
  lane_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({|rd_data_o[23:16], |rd_data_o[15:8], |rd_data_o[7:0]}) <= 1);

  // R4
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && rd_addr_i != 2'd3 && !word_done) |=> !rx_full_o);

  // R4
  full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full_o) |-> $past(word_done));

  // R7
  ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_o) |-> ($past(rx_full_o) && $past(word_done)));

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && rd_addr_i == 2'd0 && $past(rd_i && rd_addr_i == 2'd0) && !$past(word_done))
      |-> $stable(rd_data_o));
endmodule

bind serial_rx_lanes srx_checker u_srx_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_i      (rd_i),
  .rd_addr_i (rd_addr_i),
  .rd_data_o (rd_data_o),
  .rx_full_o (rx_full_o),
  .overrun_o (overrun_o),
  .word_done (word_done)
);

// File: tb/serial_rx_lanes_bench.sv
module serial_rx_lanes_bench;
  localparam int DIV  = 2;
  localparam int BINT = 16 * DIV;
  localparam int BEXT = 16 * 6;

  logic        clk, rst_n, rxd_i, clk_src_i, ext_clk_i, rd_i;
  logic [2:0]  fmt_sel_i;
  logic [1:0]  rd_addr_i;
  logic [23:0] rd_data_o;
  logic        rx_full_o, overrun_o, frame_err_o;

  int checks = 0, failures = 0, ext_cnt = 0;
  bit ext_en = 0, done_flag = 0;

  serial_rx_lanes #(.DIV(DIV), .OSR(16)) u_serial_rx_lanes (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (ext_en) begin
      ext_cnt++;
      if (ext_cnt == 3) begin
        ext_clk_i = ~ext_clk_i;
        ext_cnt = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [8:0] bits, input int n, input logic stopv, input int bc);
    @(negedge clk) rxd_i = 1'b0;
    repeat (bc - 1) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rxd_i = bits[i];
      repeat (bc) @(negedge clk);
    end
    rxd_i = stopv;
    repeat (bc) @(negedge clk);
    rxd_i = 1'b1;
    repeat (bc) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [23:0] d);
    @(negedge clk);
    rd_i = 1'b1;
    rd_addr_i = a;
    #1 d = rd_data_o;
    @(negedge clk);
    rd_i = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [23:0] d, acc;
    rst_n = 0; rxd_i = 1; clk_src_i = 0; ext_clk_i = 0; rd_i = 0;
    rd_addr_i = 0; fmt_sel_i = 3'b000;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    chk(!rx_full_o && !overrun_o && !frame_err_o, "R1 flags", {rx_full_o, overrun_o, frame_err_o}, 0);
    rd(2'd0, d);
    chk(d == 0, "R1 read", d, 0);

    // R2 R3 R4: full byte sweep, rotating lane
    for (int v = 0; v < 256; v++) begin
      logic [1:0] a;
      a = 2'(v % 3);
      send(9'(v), 8, 1'b1, BINT);
      chk(rx_full_o, "R4 set", rx_full_o, 1);
      rd(a, d);
      chk(d == (24'(v) << (8 * a)), "R2 R3 byte lane", d, 24'(v) << (8 * a));
      chk(!rx_full_o, "R4 clear", rx_full_o, 0);
    end

    // R3: OR packing of three reads
    acc = 0;
    for (int k = 0; k < 3; k++) begin
      send(9'(8'hA5 + 8'(k * 17)), 8, 1'b1, BINT);
      rd(2'(k), d);
      acc |= d;
    end
    chk(acc == {8'hA5 + 8'd34, 8'hA5 + 8'd17, 8'hA5}, "R3 packed", acc,
        {8'hA5 + 8'd34, 8'hA5 + 8'd17, 8'hA5});

    // R3: address 3 and idle strobe
    send(9'h3C, 8, 1'b1, BINT);
    rd(2'd3, d);
    chk(d == 0 && rx_full_o, "R3 addr3", {d, rx_full_o}, 1);
    @(negedge clk) rd_addr_i = 2'd1; #1;
    chk(rd_data_o == 0, "R3 strobe low", rd_data_o, 0);
    rd(2'd1, d);
    chk(d == 24'h003C00, "R3 mid", d, 24'h003C00);

    // R5: 7 data bits + parity, both codes, parity ignored
    for (int v = 0; v < 128; v += 9) begin
      logic par;
      par = ^v[6:0];
      fmt_sel_i = (v % 2 == 0) ? 3'b001 : 3'b010;
      send({1'b0, ~par ^ v[0], 7'(v)}, 8, 1'b1, BINT);
      rd(2'd0, d);
      chk(d == 24'(v), "R5 seven bit", d, v);
    end

    // R6: 9-bit format and reserved codes
    fmt_sel_i = 3'b011;
    for (int v = 0; v < 4; v++) begin
      logic [8:0] w;
      w = {v[0], 8'h5A ^ 8'(v * 51)};
      send(w, 9, 1'b1, BINT);
      rd(2'd2, d);
      chk(d == {w[7:0], 16'h0}, "R6 nine bit", d, {w[7:0], 16'h0});
      chk(!frame_err_o, "R6 nine stop", frame_err_o, 0);
    end
    for (int c = 4; c < 8; c++) begin
      fmt_sel_i = 3'(c);
      send(9'(8'hC3 ^ 8'(c)), 8, 1'b1, BINT);
      rd(2'd0, d);
      chk(d == 24'(8'hC3 ^ 8'(c)), "R6 reserved", d, 8'hC3 ^ 8'(c));
    end
    fmt_sel_i = 3'b000;

    // R7: overrun keeps old byte
    send(9'h11, 8, 1'b1, BINT);
    send(9'h22, 8, 1'b1, BINT);
    chk(overrun_o && rx_full_o, "R7 set", {overrun_o, rx_full_o}, 3);
    rd(2'd0, d);
    chk(d == 24'h11, "R7 old kept", d, 24'h11);
    chk(!overrun_o && !rx_full_o, "R7 clear", {overrun_o, rx_full_o}, 0);

    // R8: framing error
    send(9'h96, 8, 1'b0, BINT);
    chk(frame_err_o && rx_full_o, "R8 set", {frame_err_o, rx_full_o}, 3);
    rd(2'd0, d);
    chk(d == 24'h96, "R8 byte", d, 24'h96);
    send(9'h69, 8, 1'b1, BINT);
    chk(!frame_err_o, "R8 clear", frame_err_o, 0);
    rd(2'd0, d);

    // R9: glitch shorter than half a bit
    @(negedge clk) rxd_i = 1'b0;
    repeat (3 * DIV) @(negedge clk);
    rxd_i = 1'b1;
    repeat (12 * BINT) @(negedge clk);
    chk(!rx_full_o, "R9 glitch", rx_full_o, 0);
    send(9'h81, 8, 1'b1, BINT);
    rd(2'd0, d);
    chk(d == 24'h81, "R9 after glitch", d, 24'h81);

    // R10: external clock source
    clk_src_i = 1'b1;
    ext_en = 1;
    repeat (20) @(negedge clk);
    send(9'hE7, 8, 1'b1, BEXT);
    chk(rx_full_o, "R10 ext full", rx_full_o, 1);
    rd(2'd1, d);
    chk(d == 24'h00E700, "R10 ext byte", d, 24'h00E700);
    ext_en = 0;
    clk_src_i = 1'b0;
    repeat (20) @(negedge clk);

    // R11: old byte readable while the next one shifts in
    send(9'h4D, 8, 1'b1, BINT);
    fork
      send(9'hB2, 8, 1'b1, BINT);
      begin
        logic [23:0] dd;
        repeat (4 * BINT) @(negedge clk);
        rd(2'd0, dd);
        chk(dd == 24'h4D, "R11 old during shift", dd, 24'h4D);
      end
    join
    chk(rx_full_o && !overrun_o, "R11 next arrived", {rx_full_o, overrun_o}, 2);
    rd(2'd0, d);
    chk(d == 24'hB2, "R11 new byte", d, 24'hB2);

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule